// File: doc/BRIEF.md
# Amplifier Standby and Mute Power Sequencer

This block sits between the control registers of a piezo speaker amplifier and the analog enables that switch the amplifier and its charge pump. Software or pin logic states what it wants: standby on or off, speaker output muted or not, device shut down or not. The sequencer turns those wishes into enable changes in an order that does not pop. Standby is always released before the speaker output is un-muted. Muting always comes before standby on the way down. Shutdown only takes effect once the charge pump has had time to discharge.

The enforced waits are parameters in milliseconds. The bias pre-charge wait is 30 ms and is never shorter than the charge-pump rise time. The minimum time between releasing standby and asserting it again is 5 ms. The charge-pump fall time before shutdown or a new power-up is 3 ms. All waits are counted against one shared millisecond tick, which a prescaler derives from the system clock. Each timer loads one tick more than the nominal count. Because of that, a wait is never shorter than its nominal length, whatever the phase of the tick.

Top module: `amp_power_seq`

## Requirements
- R1: While reset is held and just after it is released, standby and mute are both asserted (1), shutdown is deasserted (0) and busy is 0.
- R2: When standby is no longer requested, the standby enable drops one clock after the request is sampled. The mute enable is then released no sooner than SETTLE_MS·CLKS_PER_MS clocks, and no later than (SETTLE_MS+1)·CLKS_PER_MS+2 clocks, after standby dropped.
- R3: A mute request still held when the pre-charge wait starts keeps mute asserted. If the request is withdrawn during the wait, the un-mute is held pending and applied within the same window as R2.
- R4: From the playing state, a standby request asserts mute one clock later and asserts standby exactly one clock after mute, never before it.
- R5: A standby request made less than GAP_MS after standby was released is deferred. Standby stays 0 and mute stays 1 until GAP_MS has elapsed, and standby rises by (GAP_MS+1)·CLKS_PER_MS+2 clocks after the release.
- R6: A shutdown request while playing asserts mute, then standby one clock later, and asserts the shutdown enable only after at least FALL_MS·CLKS_PER_MS clocks of standby. From an idle standby state the shutdown enable rises one clock after the request.
- R7: Once standby has been asserted, it stays asserted for at least FALL_MS, even if standby is no longer requested. After that wait the power-up of R2 starts on its own.
- R8: busy is 1 during the pre-charge wait and during the charge-pump fall wait, and 0 while playing or idle in standby.
- R9: While playing, a mute request sets mute one clock later with standby unchanged at 0. Withdrawing it clears mute one clock later, with no new pre-charge wait.
- R10: Withdrawing shutdown while standby is still requested clears the shutdown enable one clock later and leaves standby and mute asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_stby | input | 1 | Requested standby state (1 = standby) |
| req_mute | input | 1 | Requested speaker mute (1 = muted) |
| req_shdn | input | 1 | Requested shutdown (1 = shut down) |
| stby_en | output | 1 | Standby enable to amplifier and charge pump (1 = standby) |
| mute_en | output | 1 | Speaker mute enable (1 = muted) |
| shdn_en | output | 1 | Shutdown permitted and in effect |
| busy | output | 1 | An enforced wait is in progress |

## Verification
A request change reaches every enable one clock after it is sampled, because the enables are registered copies of the next state. Millisecond waits end somewhere inside a window one tick wide, because the tick phase is free-running. The bench therefore checks a window around each timed result. It samples just before the earliest legal change to see the old value. It then samples after the latest legal change, (N+1)·CLKS_PER_MS+2 clocks later, to see the new value. Where an earlier wait leaves the start of a later one uncertain, the bench polls for the standby edge and measures from there. Every sample is taken one time unit after a rising edge, when all registers have settled.

// File: rtl/pseq_pkg.sv
package pseq_pkg;

   typedef enum logic [2:0] {
      ST_OFF    = 3'd0,
      ST_SETTLE = 3'd1,
      ST_MUTED  = 3'd2,
      ST_PLAY   = 3'd3,
      ST_DRAIN  = 3'd4,
      ST_SHDN   = 3'd5
   } pseq_state_t;

   function automatic int unsigned pseq_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pseq_ms_tick.sv
module pseq_ms_tick #(
   parameter int unsigned CLKS_PER_MS = 1000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int unsigned CW = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;

   if (CLKS_PER_MS < 1) begin : g_bad_div
      $error("CLKS_PER_MS must be at least 1");
   end

   if (CLKS_PER_MS == 1) begin : g_every_clk
      logic tick_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) tick_q <= 1'b0;
         else        tick_q <= 1'b1;
      end
      assign tick = tick_q;
   end else begin : g_divider
      logic [CW-1:0] div_q;
      localparam logic [CW-1:0] LAST = CW'(CLKS_PER_MS - 1);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              div_q <= '0;
         else if (div_q == LAST)  div_q <= '0;
         else                     div_q <= div_q + 1'b1;
      end
      assign tick = (div_q == LAST);

      p_tick_period_r2 : assert property (@(posedge clk) disable iff (!rst_n)
         tick |=> !tick);
   end

endmodule

// File: rtl/pseq_ms_timer.sv
module pseq_ms_timer #(
   parameter int unsigned TW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   output logic          done
);
   if (TW < 2) begin : g_bad_width
      $error("timer width too small");
   end

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cnt_q <= '0;
      else if (load)                    cnt_q <= load_val;
      else if (tick && cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);

   p_no_tick_no_move_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !tick) |=> $stable(cnt_q));
   p_load_arms_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (load && load_val != '0) |=> !done);

endmodule

// File: rtl/pseq_fsm.sv
module pseq_fsm
   import pseq_pkg::*;
#(
   parameter int unsigned TW        = 6,
   parameter int unsigned SETTLE_MS = 30,
   parameter int unsigned GAP_MS    = 5,
   parameter int unsigned FALL_MS   = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_stby,
   input  logic          req_mute,
   input  logic          req_shdn,
   input  logic          a_done,
   input  logic          g_done,
   output logic          a_load,
   output logic [TW-1:0] a_val,
   output logic          g_load,
   output logic          stby_en,
   output logic          mute_en,
   output logic          shdn_en,
   output logic          busy
);
   localparam logic [TW-1:0] SETTLE_LD = TW'(SETTLE_MS + 1);
   localparam logic [TW-1:0] FALL_LD   = TW'(FALL_MS + 1);

   pseq_state_t st_q, st_d;
   logic        down_req;

   assign down_req = req_stby | req_shdn;

   always_comb begin
      st_d   = st_q;
      a_load = 1'b0;
      a_val  = '0;
      g_load = 1'b0;
      unique case (st_q)
         ST_OFF: begin
            if (req_shdn) st_d = ST_SHDN;
            else if (!req_stby) begin
               st_d   = ST_SETTLE;
               a_load = 1'b1;
               a_val  = SETTLE_LD;
               g_load = 1'b1;
            end
         end
         ST_SETTLE: begin
            if (down_req) begin
               if (g_done) begin
                  st_d   = ST_DRAIN;
                  a_load = 1'b1;
                  a_val  = FALL_LD;
               end
            end else if (a_done) begin
               st_d = req_mute ? ST_MUTED : ST_PLAY;
            end
         end
         ST_MUTED: begin
            if (down_req) begin
               if (g_done) begin
                  st_d   = ST_DRAIN;
                  a_load = 1'b1;
                  a_val  = FALL_LD;
               end
            end else if (!req_mute) begin
               st_d = ST_PLAY;
            end
         end
         ST_PLAY: begin
            if (down_req || req_mute) st_d = ST_MUTED;
         end
         ST_DRAIN: begin
            if (a_done) st_d = ST_OFF;
         end
         ST_SHDN: begin
            if (!req_shdn) st_d = ST_OFF;
         end
         default: st_d = ST_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_OFF;
         stby_en <= 1'b1;
         mute_en <= 1'b1;
         shdn_en <= 1'b0;
      end else begin
         st_q    <= st_d;
         stby_en <= (st_d == ST_OFF) || (st_d == ST_DRAIN) || (st_d == ST_SHDN);
         mute_en <= (st_d != ST_PLAY);
         shdn_en <= (st_d == ST_SHDN);
      end
   end

   assign busy = (st_q == ST_SETTLE) || (st_q == ST_DRAIN) ||
                 ((st_q == ST_MUTED) && down_req && !g_done);

   p_mute_leads_stby_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stby_en) |-> $past(mute_en));
   p_play_needs_power_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      !mute_en |-> !stby_en);
   p_shdn_safe_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      shdn_en |-> (stby_en && mute_en));
   p_gap_respected_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(stby_en) && !shdn_en) |-> $past(g_done));
   p_drain_hold_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_DRAIN && !a_done) |=> stby_en);
   p_unmute_after_expiry_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mute_en) |-> $past(a_done));

endmodule

// File: rtl/amp_power_seq.sv
module amp_power_seq
   import pseq_pkg::*;
#(
   parameter int unsigned CLKS_PER_MS = 1000,
   parameter int unsigned UNMUTE_MS   = 30,
   parameter int unsigned CP_RISE_MS  = 2,
   parameter int unsigned GAP_MS      = 5,
   parameter int unsigned FALL_MS     = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_stby,
   input  logic req_mute,
   input  logic req_shdn,
   output logic stby_en,
   output logic mute_en,
   output logic shdn_en,
   output logic busy
);
   localparam int unsigned SETTLE_MS = pseq_max(UNMUTE_MS, CP_RISE_MS);
   localparam int unsigned MAX_MS    = pseq_max(SETTLE_MS, pseq_max(GAP_MS, FALL_MS));
   localparam int unsigned TW        = pseq_max($clog2(MAX_MS + 2), 2);

   if (SETTLE_MS < 1 || GAP_MS < 1 || FALL_MS < 1) begin : g_bad_wait
      $error("all waits must be at least 1 ms");
   end

   logic          tick;
   logic          a_load, g_load, a_done, g_done;
   logic [TW-1:0] a_val;

   pseq_ms_tick #(.CLKS_PER_MS(CLKS_PER_MS)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick(tick));

   pseq_ms_timer #(.TW(TW)) u_wait (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .load(a_load), .load_val(a_val), .done(a_done));

   pseq_ms_timer #(.TW(TW)) u_gap (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .load(g_load), .load_val(TW'(GAP_MS + 1)), .done(g_done));

   pseq_fsm #(
      .TW(TW), .SETTLE_MS(SETTLE_MS), .GAP_MS(GAP_MS), .FALL_MS(FALL_MS)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .req_stby(req_stby), .req_mute(req_mute), .req_shdn(req_shdn),
      .a_done(a_done), .g_done(g_done),
      .a_load(a_load), .a_val(a_val), .g_load(g_load),
      .stby_en(stby_en), .mute_en(mute_en), .shdn_en(shdn_en), .busy(busy));

   // checker: clocks elapsed since standby dropped, saturating at the settle window
   localparam int unsigned LIM = SETTLE_MS * CLKS_PER_MS;
   localparam int unsigned LW  = $clog2(LIM + 1);
   logic [LW-1:0] rel_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    rel_cnt <= '0;
      else if (stby_en)              rel_cnt <= '0;
      else if (rel_cnt != LW'(LIM))  rel_cnt <= rel_cnt + 1'b1;
   end

   p_settle_window_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mute_en) |-> (rel_cnt >= LW'(LIM)));

endmodule

// File: tb/tb_amp_power_seq.sv
module tb_amp_power_seq;
   localparam int CLK_PERIOD = 10;
   localparam int P      = 10;
   localparam int N_SET  = 30;
   localparam int N_GAP  = 5;
   localparam int N_FALL = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_stby = 1'b1, req_mute = 1'b1, req_shdn = 1'b0;
   logic stby_en, mute_en, shdn_en, busy;
   int   n_run = 0, n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   amp_power_seq #(.CLKS_PER_MS(P)) dut (
      .clk(clk), .rst_n(rst_n),
      .req_stby(req_stby), .req_mute(req_mute), .req_shdn(req_shdn),
      .stby_en(stby_en), .mute_en(mute_en), .shdn_en(shdn_en), .busy(busy));

   task automatic check(input string req, input string what, input logic act, input logic exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      #1;
   endtask

   task automatic wait_stby_low(input string req);
      int k = 0;
      while (stby_en !== 1'b0 && k < 100*P) begin
         step(1);
         k++;
      end
      check(req, "standby released within bound", stby_en, 1'b0);
   endtask

   task automatic t_reset;
      check("R1", "stby in reset", stby_en, 1'b1);
      check("R1", "mute in reset", mute_en, 1'b1);
      rst_n = 1'b1;
      step(2);
      check("R1", "stby after reset", stby_en, 1'b1);
      check("R1", "mute after reset", mute_en, 1'b1);
      check("R1", "shdn after reset", shdn_en, 1'b0);
      check("R1", "busy after reset", busy, 1'b0);
   endtask

   task automatic t_powerup;
      req_mute = 1'b0;
      req_stby = 1'b0;
      step(1);
      check("R2", "stby drops one clock later", stby_en, 1'b0);
      check("R2", "mute held at release", mute_en, 1'b1);
      check("R8", "busy in pre-charge", busy, 1'b1);
      step(N_SET*P);
      check("R2", "mute still held at window start", mute_en, 1'b1);
      step(P+2);
      check("R2", "mute released by window end", mute_en, 1'b0);
      check("R8", "busy clear while playing", busy, 1'b0);
   endtask

   task automatic t_mute_in_play;
      req_mute = 1'b1;
      step(1);
      check("R9", "mute set", mute_en, 1'b1);
      check("R9", "stby unchanged", stby_en, 1'b0);
      req_mute = 1'b0;
      step(1);
      check("R9", "mute cleared without wait", mute_en, 1'b0);
   endtask

   task automatic t_powerdown;
      req_stby = 1'b1;
      step(1);
      check("R4", "mute first", mute_en, 1'b1);
      check("R4", "stby not yet", stby_en, 1'b0);
      step(1);
      check("R4", "stby follows", stby_en, 1'b1);
      check("R8", "busy in fall wait", busy, 1'b1);
      req_stby = 1'b0;
      req_mute = 1'b1;
      step(N_FALL*P);
      check("R7", "stby held through fall wait", stby_en, 1'b1);
      wait_stby_low("R7");
   endtask

   task automatic t_pending_unmute;
      step(10*P);
      check("R3", "mute held while requested", mute_en, 1'b1);
      req_mute = 1'b0;
      step((N_SET-10)*P);
      check("R3", "pending unmute not early", mute_en, 1'b1);
      step(P+2);
      check("R3", "pending unmute applied", mute_en, 1'b0);
   endtask

   task automatic t_gap;
      req_stby = 1'b1;
      step(2);
      check("R4", "stby on for gap test", stby_en, 1'b1);
      req_stby = 1'b0;
      wait_stby_low("R5");
      step(P);
      req_stby = 1'b1;
      step((N_GAP-1)*P);
      check("R5", "stby deferred in gap", stby_en, 1'b0);
      check("R5", "mute kept in gap", mute_en, 1'b1);
      step(P+2);
      check("R5", "stby applied after gap", stby_en, 1'b1);
   endtask

   task automatic t_shutdown;
      step(5*P);
      req_shdn = 1'b1;
      step(1);
      check("R6", "shdn from idle standby", shdn_en, 1'b1);
      req_shdn = 1'b0;
      step(1);
      check("R10", "shdn withdrawn", shdn_en, 1'b0);
      check("R10", "stby kept", stby_en, 1'b1);
      check("R10", "mute kept", mute_en, 1'b1);
      req_stby = 1'b0;
      wait_stby_low("R6");
      step((N_SET+2)*P);
      check("R6", "playing before shutdown", mute_en, 1'b0);
      req_shdn = 1'b1;
      step(1);
      check("R6", "mute first on shutdown", mute_en, 1'b1);
      check("R6", "stby not yet on shutdown", stby_en, 1'b0);
      step(1);
      check("R6", "stby second on shutdown", stby_en, 1'b1);
      check("R6", "shdn not early", shdn_en, 1'b0);
      step(N_FALL*P);
      check("R6", "shdn held off during fall", shdn_en, 1'b0);
      step(P+3);
      check("R6", "shdn in effect", shdn_en, 1'b1);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      step(3);
      t_reset();
      t_powerup();
      t_mute_in_play();
      t_powerdown();
      t_pending_unmute();
      t_gap();
      t_shutdown();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule